// File: doc/BRIEF.md
# Eight-Lane Slotted Serial Deframer

This block sits at the receiving end of a sensor array in which twelve boards share each serial lane by time division. Eight such lanes arrive in parallel. A one-cycle strobe, `bit_en`, marks the instant the shared bit clock falls, and on that strobe every lane contributes one bit. Each lane's bits are packed into 32-bit words, and eight words make one 256-bit frame. A frame is cut into twelve 21-bit slots followed by four idle bits.

From each slot the block takes an 18-bit sample. It also checks the fixed framing bits around every sample, so a board that has drifted out of its slot is noticed at once. Samples leave as a stream of channel-tagged values. Framing errors are kept as sticky per-lane flags and as a saturating count.

The frame position is restarted by a one-cycle pulse from the alignment sequencer once the array's timing reset has ended. The same pulse clears all error state. Downstream logic can stall the stream with `smp_ready`. If that stall lasts long enough that a completed word cannot be taken, the overrun flag rises.

Top module: `tdm_deframer`

## Requirements
- R1: On each cycle with `bit_en` high and `align_done` low, one bit is taken from every lane. The first such bit after reset or after `align_done` is frame bit 0, and frame bits count 0 to 255 and then wrap to 0.
- R2: Each lane's bits are packed into 32-bit words with the first received bit in bit 31. Word k of a frame holds frame bits 32k to 32k+31.
- R3: The sample of slot s (s = 0..11) is frame bits 21s+1 to 21s+18 of its lane. The first received of those bits is sample bit 17.
- R4: `smp_chan` equals lane*12 + slot. Samples are emitted in ascending slot order, and within each slot for lanes 0 to 7 in ascending order. The samples of slot s are emitted after the word holding frame bit 21s+18 completes.
- R5: On every lane, frame bit 21s must be 1 and bits 21s+19 and 21s+20 must be 0 for s = 0..11, and frame bits 252 to 255 must be 0. A mismatch on lane L sets `sync_err[L]`, which stays set until `align_done`.
- R6: `err_count` rises by exactly one for each completed word in which at least one lane has a framing mismatch, however many lanes mismatch. It stops at 65535.
- R7: While `smp_valid` is high and `smp_ready` is low, `smp_valid`, `smp_chan` and `smp_data` hold. With `smp_ready` high, one sample is taken per cycle.
- R8: `overrun` is set, and stays set until `align_done`, when a word completes while the previously completed word has not yet been taken by the sample emitter. The newer word then replaces the waiting one.
- R9: `align_done` clears the frame position, `sync_err`, `err_count`, `overrun`, any waiting word and any sample emission in progress. A `bit_en` in the same cycle is ignored.
- R10: After a synchronous reset (`rst_n` low at a clock edge), `smp_valid`, `sync_err`, `err_count` and `overrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| align_done | input | 1 | One-cycle restart pulse from the alignment sequencer |
| bit_en | input | 1 | Strobe marking a falling edge of the bit clock |
| lane_in | input | 8 | One data bit per lane, sampled on `bit_en` |
| smp_ready | input | 1 | Downstream can accept a sample this cycle |
| smp_valid | output | 1 | A sample is presented |
| smp_chan | output | 7 | Channel number, lane*12 + slot |
| smp_data | output | 18 | Sample value |
| sync_err | output | 8 | Sticky per-lane framing-error flags |
| err_count | output | 16 | Saturating count of words with framing errors |
| overrun | output | 1 | Sticky flag for a completed word lost before it was taken |

## Verification
On every cycle, the assertions check the following:
- the word-boundary wrap of the bit position;
- that the error flags stay sticky and the error count moves by at most one and saturates;
- that a stalled sample holds;
- that a reported channel lies within 0..95;
- that overrun stays sticky and the restart pulse clears all error state.

Only the bench's scenarios can show the rest: that the right bits of the right lane come out as each sample, in slot-major order with the correct channel number. The scenarios also show that particular marker corruptions raise the right lane flags and count once per word, that overrun appears exactly when the third word completes under a stall, and that a restart mid-frame re-aligns the frame.

// File: rtl/tdm_deframer_pkg.sv
// Package: layout constants of the slotted lane frame and helper functions
// that decode where markers and samples sit in a 32-bit word.
// Assumes 8 lanes, 32-bit words, 8 words per frame, 12 slots of 21 bits.
package tdm_deframer_pkg;

    localparam int unsigned LANES      = 8;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned WORDS      = 8;
    localparam int unsigned SLOT_BITS  = 21;
    localparam int unsigned SLOTS      = 12;
    localparam int unsigned SAMPLE_W   = 18;
    localparam int unsigned ERR_W      = 16;
    localparam int unsigned TAIL_START = SLOT_BITS * SLOTS;
    localparam int unsigned BIT_CW     = $clog2(WORD_W);
    localparam int unsigned WIDX_W     = $clog2(WORDS);
    localparam int unsigned SLOT_CW    = $clog2(SLOTS + 1);
    localparam int unsigned LANE_CW    = $clog2(LANES);
    localparam int unsigned CHAN_W     = $clog2(LANES * SLOTS);
    localparam int unsigned WIN_W      = 2 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    // Bits of word w that must be 1 (slot start markers).
    function automatic word_t ones_mask(input logic [WIDX_W-1:0] w);
        word_t m;
        int unsigned p;
        m = '0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            p = 32'(w) * WORD_W + (WORD_W - 1 - 32'(i));
            if (p < TAIL_START && (p % SLOT_BITS) == 0) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Bits of word w that must be 0 (slot trailers and frame tail).
    function automatic word_t zeros_mask(input logic [WIDX_W-1:0] w);
        word_t m;
        int unsigned p;
        m = '0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            p = 32'(w) * WORD_W + (WORD_W - 1 - 32'(i));
            if (p >= TAIL_START || (p % SLOT_BITS) > SAMPLE_W) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Index of the word in which the last sample bit of slot s arrives;
    // WORDS for an out-of-range slot so that it never matches.
    function automatic logic [WIDX_W:0] end_word(input logic [SLOT_CW-1:0] s);
        if (32'(s) >= SLOTS) return (WIDX_W+1)'(WORDS);
        return (WIDX_W+1)'((32'(s) * SLOT_BITS + SAMPLE_W) / WORD_W);
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
// Frame timer: counts bit strobes into a bit-in-word and word-in-frame
// position and flags the strobe that completes each word.
// Assumes align_done outranks bit_en in the same cycle.
module tdm_frame_timer
    import tdm_deframer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align_done,
    input  logic              bit_en,
    output logic [WIDX_W-1:0] word_idx,
    output logic              word_done
);

    logic [BIT_CW-1:0] bit_cnt;
    logic [WIDX_W-1:0] word_cnt;

    // Word completes on the strobe carrying the last bit of a word.
    always_comb word_done = bit_en && !align_done && (bit_cnt == BIT_CW'(WORD_W - 1));
    assign word_idx = word_cnt;

    // Advance bit and word position; restart on reset or alignment.
    always_ff @(posedge clk) begin
        if (!rst_n || align_done) begin
            bit_cnt  <= '0;
            word_cnt <= '0;
        end else if (bit_en) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BIT_CW'(WORD_W - 1)) word_cnt <= word_cnt + 1'b1;
        end
    end

    a_r1_word_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !align_done && bit_cnt == BIT_CW'(WORD_W - 1)) |=> (bit_cnt == '0))
        else $error("a_r1_word_wrap");

endmodule

// File: rtl/tdm_lane_packer.sv
// Lane packer: shifts one lane's bits into a word, first bit ending in
// the MSB, and presents the word including the bit arriving now.
// Assumes the shared frame timer decides when the word is complete.
module tdm_lane_packer
    import tdm_deframer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  align_done,
    input  logic  bit_en,
    input  logic  bit_in,
    output word_t word_now
);

    logic [WORD_W-2:0] shreg;

    assign word_now = {shreg, bit_in};

    // Shift in the lane bit on each accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || align_done) shreg <= '0;
        else if (bit_en)          shreg <= {shreg[WORD_W-3:0], bit_in};
    end

endmodule

// File: rtl/tdm_marker_check.sv
// Marker checker: compares each completed word of every lane against the
// fixed slot markers, keeps sticky per-lane flags and a saturating count
// of words containing any mismatch.
// Assumes word_idx gives the frame position of the word completing now.
module tdm_marker_check
    import tdm_deframer_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           align_done,
    input  logic                           word_done,
    input  logic [WIDX_W-1:0]              word_idx,
    input  logic [LANES-1:0][WORD_W-1:0]   words,
    output logic [LANES-1:0]               sync_err,
    output logic [ERR_W-1:0]               err_count
);

    logic [LANES-1:0] lane_bad;
    word_t            need_one, need_zero;

    // Per-lane mismatch of the completing word against the marker masks.
    always_comb begin
        need_one  = ones_mask(word_idx);
        need_zero = zeros_mask(word_idx);
        for (int l = 0; l < int'(LANES); l++)
            lane_bad[l] = word_done && |((~words[l] & need_one) | (words[l] & need_zero));
    end

    // Sticky flags and saturating word-error count.
    always_ff @(posedge clk) begin
        if (!rst_n || align_done) begin
            sync_err  <= '0;
            err_count <= '0;
        end else begin
            sync_err <= sync_err | lane_bad;
            if (|lane_bad && err_count != '1) err_count <= err_count + 1'b1;
        end
    end

    a_r5_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !align_done |=> ((sync_err & $past(sync_err)) == $past(sync_err)))
        else $error("a_r5_sticky_flags");

    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !align_done |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1))
        else $error("a_r6_count_step");

    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == '1 && !align_done) |=> (err_count == '1))
        else $error("a_r6_saturate");

endmodule

// File: rtl/tdm_sample_emitter.sv
// Sample emitter: takes one completed word per lane into a two-word
// window, then presents every sample whose last bit lies in that word,
// slot-major, one per accepted cycle.
// Assumes at most two slots end in any word and no slot spans 3 words.
module tdm_sample_emitter
    import tdm_deframer_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           align_done,
    input  logic                           take_valid,
    input  logic [WIDX_W-1:0]              take_idx,
    input  logic [LANES-1:0][WORD_W-1:0]   take_words,
    output logic                           take,
    input  logic                           smp_ready,
    output logic                           smp_valid,
    output logic [CHAN_W-1:0]              smp_chan,
    output logic [SAMPLE_W-1:0]            smp_data
);

    logic [LANES-1:0][WIN_W-1:0] win;
    logic [WIDX_W-1:0]           win_idx;
    logic [SLOT_CW-1:0]          cur_slot;
    logic [LANE_CW-1:0]          cur_lane;
    logic                        busy;
    logic                        match;

    // A sample is ready when the current slot ends in the held word.
    always_comb begin
        match = busy && (end_word(cur_slot) == {1'b0, win_idx});
        take  = take_valid && !busy;
    end

    assign smp_valid = match;
    assign smp_chan  = CHAN_W'(32'(cur_lane) * SLOTS + 32'(cur_slot));

    // Cut the current lane's sample out of the two-word window.
    always_comb begin
        int unsigned       ofs;
        logic [WIN_W-1:0]  shifted;
        ofs = 0;
        if (match) ofs = 32'(cur_slot) * SLOT_BITS + 1 + WORD_W - 32'(win_idx) * WORD_W;
        shifted  = win[cur_lane] << ofs;
        smp_data = shifted[WIN_W-1 -: SAMPLE_W];
    end

    // Take words, then walk slots and lanes until no slot ends here.
    always_ff @(posedge clk) begin
        if (!rst_n || align_done) begin
            busy     <= 1'b0;
            win      <= '0;
            win_idx  <= '0;
            cur_slot <= '0;
            cur_lane <= '0;
        end else if (take) begin
            busy    <= 1'b1;
            win_idx <= take_idx;
            cur_lane <= '0;
            if (take_idx == '0) cur_slot <= '0;
            for (int l = 0; l < int'(LANES); l++)
                win[l] <= {win[l][WORD_W-1:0], take_words[l]};
        end else if (busy) begin
            if (!match) begin
                busy <= 1'b0;
            end else if (smp_ready) begin
                if (cur_lane == LANE_CW'(LANES - 1)) begin
                    cur_lane <= '0;
                    cur_slot <= cur_slot + 1'b1;
                end else begin
                    cur_lane <= cur_lane + 1'b1;
                end
            end
        end
    end

    a_r4_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (32'(smp_chan) < LANES * SLOTS))
        else $error("a_r4_chan_range");

    a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready && !align_done) |=>
            (smp_valid && $stable(smp_chan) && $stable(smp_data)))
        else $error("a_r7_hold_stall");

endmodule

// File: rtl/tdm_deframer.sv
// Top: eight-lane slotted deframer. Packs lanes into words, checks slot
// markers per word, holds one completed word for the sample emitter and
// flags an overrun when a word completes before the last was taken.
// Assumes bit_en is a single-cycle strobe in the clk domain.
module tdm_deframer
    import tdm_deframer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                align_done,
    input  logic                bit_en,
    input  logic [LANES-1:0]    lane_in,
    input  logic                smp_ready,
    output logic                smp_valid,
    output logic [CHAN_W-1:0]   smp_chan,
    output logic [SAMPLE_W-1:0] smp_data,
    output logic [LANES-1:0]    sync_err,
    output logic [ERR_W-1:0]    err_count,
    output logic                overrun
);

    logic [LANES-1:0][WORD_W-1:0] words_now;
    logic [LANES-1:0][WORD_W-1:0] pend_words;
    logic [WIDX_W-1:0]            word_idx;
    logic [WIDX_W-1:0]            pend_idx;
    logic                         word_done;
    logic                         pending;
    logic                         take;

    tdm_frame_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .align_done (align_done),
        .bit_en     (bit_en),
        .word_idx   (word_idx),
        .word_done  (word_done)
    );

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        tdm_lane_packer u_pack (
            .clk        (clk),
            .rst_n      (rst_n),
            .align_done (align_done),
            .bit_en     (bit_en),
            .bit_in     (lane_in[g]),
            .word_now   (words_now[g])
        );
    end

    tdm_marker_check u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .align_done (align_done),
        .word_done  (word_done),
        .word_idx   (word_idx),
        .words      (words_now),
        .sync_err   (sync_err),
        .err_count  (err_count)
    );

    // Hold the latest completed word set; flag one that arrives too soon.
    always_ff @(posedge clk) begin
        if (!rst_n || align_done) begin
            pending    <= 1'b0;
            overrun    <= 1'b0;
            pend_idx   <= '0;
            pend_words <= '0;
        end else if (word_done) begin
            pend_words <= words_now;
            pend_idx   <= word_idx;
            pending    <= 1'b1;
            if (pending && !take) overrun <= 1'b1;
        end else if (take) begin
            pending <= 1'b0;
        end
    end

    tdm_sample_emitter u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .align_done (align_done),
        .take_valid (pending),
        .take_idx   (pend_idx),
        .take_words (pend_words),
        .take       (take),
        .smp_ready  (smp_ready),
        .smp_valid  (smp_valid),
        .smp_chan   (smp_chan),
        .smp_data   (smp_data)
    );

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !align_done) |=> overrun)
        else $error("a_r8_overrun_sticky");

    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        align_done |=> (sync_err == '0 && err_count == '0 && !overrun && !smp_valid))
        else $error("a_r9_restart_clears");

endmodule

// File: tb/tdm_deframer_test.sv
// Scoreboard bench: the frame builder pushes expected samples into a queue,
// a monitor pops and compares each sample the design hands over.
module tdm_deframer_test;
    import tdm_deframer_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic align_done = 1'b0;
    logic bit_en = 1'b0;
    logic [7:0] lane_in = '0;
    logic smp_ready;
    logic smp_valid;
    logic [6:0] smp_chan;
    logic [17:0] smp_data;
    logic [7:0] sync_err;
    logic [15:0] err_count;
    logic overrun;

    tdm_deframer uut (
        .clk(clk), .rst_n(rst_n), .align_done(align_done), .bit_en(bit_en),
        .lane_in(lane_in), .smp_ready(smp_ready), .smp_valid(smp_valid),
        .smp_chan(smp_chan), .smp_data(smp_data), .sync_err(sync_err),
        .err_count(err_count), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [6:0]  chan;
        logic [17:0] data;
    } exp_t;

    int   checks = 0;
    int   fails = 0;
    exp_t expq[$];
    bit   mon_on = 1'b0;
    int   ready_mode = 1;   // 0: stalled, 1: always ready, 2: toggling
    int   cyc = 0;
    logic [255:0] frm [8];
    logic [17:0]  smp [8][12];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Ready pattern driven just after each edge.
    always @(posedge clk) begin
        #1;
        if (ready_mode == 0)      smp_ready = 1'b0;
        else if (ready_mode == 1) smp_ready = 1'b1;
        else                      smp_ready = (cyc % 3) != 2;
        cyc++;
    end

    // Monitor: compare every accepted sample with the queue head (R3, R4).
    exp_t mon_e;
    always @(negedge clk) begin
        if (mon_on && rst_n && smp_valid && smp_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, "R4", "unexpected sample chan", int'(smp_chan), -1);
            end else begin
                mon_e = expq.pop_front();
                check(smp_chan == mon_e.chan, "R4", "channel order", int'(smp_chan), int'(mon_e.chan));
                check(smp_data == mon_e.data, "R3", "sample value", int'(smp_data), int'(mon_e.data));
            end
        end
    end

    // Build a frame per lane from the slot layout of R3 and R5.
    task automatic make_frame(input int seed);
        for (int l = 0; l < 8; l++)
            for (int s = 0; s < 12; s++)
                smp[l][s] = 18'(seed * 40503 + l * 9973 + s * 611 + 5);
        if (seed == 0) begin
            smp[0][0]  = 18'h3FFFF;
            smp[1][0]  = 18'h20001;
            smp[7][11] = 18'h00000;
        end
        for (int l = 0; l < 8; l++) begin
            frm[l] = '0;
            for (int s = 0; s < 12; s++) begin
                frm[l][21*s] = 1'b1;
                for (int j = 0; j < 18; j++)
                    frm[l][21*s + 1 + j] = smp[l][s][17 - j];
            end
        end
    endtask

    // Expected order: slot-major, lanes ascending, chan = lane*12 + slot.
    task automatic push_expect();
        for (int s = 0; s < 12; s++)
            for (int l = 0; l < 8; l++)
                expq.push_back('{chan: 7'(l * 12 + s), data: smp[l][s]});
    endtask

    task automatic send_bits(input int from, input int upto, input int gap);
        for (int b = from; b <= upto; b++) begin
            bit_en = 1'b1;
            for (int l = 0; l < 8; l++) lane_in[l] = frm[l][b];
            step();
            bit_en = 1'b0;
            repeat (gap) step();
        end
    endtask

    task automatic restart();
        align_done = 1'b1;
        bit_en = 1'b1;          // must be ignored (R9)
        lane_in = 8'hFF;
        step();
        align_done = 1'b0;
        bit_en = 1'b0;
        lane_in = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) step();
        check(smp_valid == 1'b0, "R10", "smp_valid after reset", int'(smp_valid), 0);
        check(sync_err == '0, "R10", "sync_err after reset", int'(sync_err), 0);
        check(err_count == '0, "R10", "err_count after reset", int'(err_count), 0);
        check(overrun == 1'b0, "R10", "overrun after reset", int'(overrun), 0);
        rst_n = 1'b1;
        step();
        align_done = 1'b1;
        step();
        align_done = 1'b0;
        mon_on = 1'b1;

        // R1 R2 R3 R4: dense strobes, extreme sample values.
        make_frame(0);
        push_expect();
        send_bits(0, 255, 0);
        repeat (40) step();
        check(expq.size() == 0, "R4", "samples left after frame 0", expq.size(), 0);
        check(sync_err == '0, "R5", "no flag on clean frame", int'(sync_err), 0);
        check(err_count == '0, "R6", "no count on clean frame", int'(err_count), 0);

        // R7: sparse strobes with downstream stalls.
        ready_mode = 2;
        make_frame(1);
        push_expect();
        send_bits(0, 255, 2);
        repeat (60) step();
        check(expq.size() == 0, "R7", "samples left under stalls", expq.size(), 0);
        check(overrun == 1'b0, "R8", "no overrun under short stalls", int'(overrun), 0);
        ready_mode = 1;

        // R5 R6: marker corruptions; two lanes share word 0.
        make_frame(2);
        push_expect();
        frm[0][19]  = 1'b1;
        frm[1][21]  = 1'b0;
        frm[3][105] = 1'b0;
        frm[6][253] = 1'b1;
        send_bits(0, 255, 0);
        repeat (40) step();
        check(expq.size() == 0, "R3", "samples left on corrupt frame", expq.size(), 0);
        check(sync_err == 8'h4B, "R5", "lane flags", int'(sync_err), 'h4B);
        check(err_count == 16'd3, "R6", "one count per bad word", int'(err_count), 3);

        // R5: flags stay set across a clean frame.
        make_frame(3);
        push_expect();
        send_bits(0, 255, 0);
        repeat (40) step();
        check(sync_err == 8'h4B, "R5", "flags sticky", int'(sync_err), 'h4B);
        check(err_count == 16'd3, "R6", "count held on clean frame", int'(err_count), 3);

        // R8: stall the emitter; third completed word overruns.
        mon_on = 1'b0;
        ready_mode = 0;
        step();
        make_frame(4);
        send_bits(0, 63, 0);
        check(overrun == 1'b0, "R8", "overrun after two words", int'(overrun), 0);
        check(smp_valid == 1'b1, "R7", "stalled sample presented", int'(smp_valid), 1);
        send_bits(64, 95, 0);
        check(overrun == 1'b1, "R8", "overrun after three words", int'(overrun), 1);
        send_bits(96, 255, 0);
        check(overrun == 1'b1, "R8", "overrun sticky", int'(overrun), 1);

        // R9: restart clears state and ignores the coincident strobe.
        restart();
        expq.delete();
        check(overrun == 1'b0, "R9", "overrun cleared", int'(overrun), 0);
        check(sync_err == '0, "R9", "flags cleared", int'(sync_err), 0);
        check(err_count == '0, "R9", "count cleared", int'(err_count), 0);
        check(smp_valid == 1'b0, "R9", "emission dropped", int'(smp_valid), 0);
        ready_mode = 1;
        step();
        mon_on = 1'b1;
        make_frame(5);
        push_expect();
        send_bits(0, 255, 1);
        repeat (40) step();
        check(expq.size() == 0, "R1", "samples left after restart", expq.size(), 0);
        check(err_count == '0, "R9", "aligned frame clean", int'(err_count), 0);

        // R9 R1: restart in mid-frame re-aligns bit 0.
        mon_on = 1'b0;
        make_frame(6);
        send_bits(0, 99, 0);
        restart();
        expq.delete();
        mon_on = 1'b1;
        make_frame(7);
        push_expect();
        send_bits(0, 255, 0);
        repeat (40) step();
        check(expq.size() == 0, "R1", "samples left after mid-frame restart", expq.size(), 0);
        check(sync_err == '0, "R9", "no flags after mid-frame restart", int'(sync_err), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule